// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the data path of a small accumulator machine. It holds the working register W and, on each request, combines W with an operand byte that the surrounding logic has already read from the register file. It returns a result byte, a pair of write enables that say whether the result goes back into W or out to the file location, and five status flags.

A request is one cycle with `req_valid_i` high, carrying an opcode, the file operand and a destination bit. The result, the write enables and the updated flags appear on the outputs after the next rising clock edge, with `res_valid_o` high for exactly that one cycle. W and the flags are updated on the same edge. Instruction decode, memory access and multiplication are left to the surrounding logic.

Opcode encoding on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 pass, 4 AND, 5 OR, 6 XOR, 7 load W. The flag vector `flags_o` packs carry in bit 0, digit carry in bit 1, zero in bit 2, overflow in bit 3 and negative in bit 4.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 produces (file + W) mod 256 and sets C (flags bit 0) to the carry out of bit 7.
- R2: Opcode 1 produces (file + W + C) mod 256, where C is the flag left by the previous request, and updates C, DC, OV and Z, N as an add does.
- R3: Opcode 2 produces (file - W) mod 256. C is 1 when file >= W (no borrow), and DC is 1 when the low nibble of file >= the low nibble of W.
- R4: For opcodes 0 and 1, DC (flags bit 1) is the carry from bit 3 into bit 4. Adding 0x9F and 0x52 yields 0xF1 with flags 0x12 (N=1, OV=0, Z=0, DC=1, C=0).
- R5: For opcodes 0, 1 and 2, OV (flags bit 3) is 1 exactly when the two's-complement result leaves the range -128..127.
- R6: For opcodes 0 to 6, Z (flags bit 2) is 1 when the 8-bit result is zero, and N (flags bit 4) equals result bit 7.
- R7: Opcodes 3 (pass: result equals file), 4 (file AND W), 5 (file OR W) and 6 (file XOR W) leave C, DC and OV unchanged.
- R8: For opcodes 0 to 6 with `dest_f_i`=0, the result is written into W and `wr_w_o` is asserted. With `dest_f_i`=1, `wr_f_o` is asserted and W is left unchanged. The two enables are never high together.
- R9: Opcode 7 loads the operand into W, asserts `wr_w_o` whatever `dest_f_i` is, returns the operand as the result and leaves all five flags unchanged.
- R10: `res_valid_o` is high in the cycle after each request and low otherwise. A cycle without a request changes neither W nor the flags.
- R11: While reset is asserted, W, the flags, `res_valid_o`, `wr_w_o` and `wr_f_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| operand_i | input | DW | File operand, or literal for load W |
| dest_f_i | input | 1 | Destination: 0 = W, 1 = file |
| res_valid_o | output | 1 | Result valid, one cycle after a request |
| result_o | output | DW | Registered result |
| wr_w_o | output | 1 | Result was written into W |
| wr_f_o | output | 1 | Result is to be written to the file location |
| w_o | output | DW | Current W contents |
| flags_o | output | 5 | {N, OV, Z, DC, C} |

## Verification
The hardest behaviour to reach from the ports is add with carry under both values of the incoming carry flag, together with each possible stale W. The carry-in is whatever the previous request left behind.

The stimulus reloads W with a literal before every operation. The sweep steps the operands so that the carry, digit-carry and overflow conditions each occur with the flag previously set and previously clear. A reference model in the bench tracks W and the flags across the whole sequence, so every carry-in the design uses is predicted from history rather than forced.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_PASS = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_LDW  = 3'd7
  } alu_op_e;

  // bit 4..0 = n, ov, z, dc, c
  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] w_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          ov_o
);
  localparam int NW = DW / 2;

  logic [DW-1:0] b;
  logic [DW:0]   full;
  logic [NW:0]   low;

  // subtract as f + ~w + 1, so carry out means no borrow
  assign b    = sub_i ? ~w_i : w_i;
  assign full = {1'b0, f_i} + {1'b0, b} + {{DW{1'b0}}, cin_i};
  assign low  = {1'b0, f_i[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin_i};

  assign sum_o = full[DW-1:0];
  assign c_o   = full[DW];
  assign dc_o  = low[NW];
  assign ov_o  = (f_i[DW-1] == b[DW-1]) && (full[DW-1] != f_i[DW-1]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] w_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = f_i & w_i;
      OP_OR:   res_o = f_i | w_i;
      OP_XOR:  res_o = f_i ^ w_i;
      default: res_o = f_i;  // pass and load W
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] operand_i,
  input  logic          dest_f_i,
  output logic          res_valid_o,
  output logic [DW-1:0] result_o,
  output logic          wr_w_o,
  output logic          wr_f_o,
  output logic [DW-1:0] w_o,
  output logic [4:0]    flags_o
);
  alu_op_e       op;
  logic          is_arith, is_logic, is_ldw, cin, to_w;
  logic [DW-1:0] w_q, res_q, sum, lg_res, res_d;
  logic          a_c, a_dc, a_ov;
  flags_t        flags_q, flags_d;
  logic          vld_q, wr_w_q, wr_f_q;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
  assign is_logic = (op == OP_PASS) || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_ldw   = (op == OP_LDW);
  assign cin      = (op == OP_SUB) || ((op == OP_ADC) && flags_q.c);
  assign to_w     = is_ldw || !dest_f_i;

  acc_alu_arith #(.DW(DW)) u_arith (
    .f_i   (operand_i),
    .w_i   (w_q),
    .sub_i (op == OP_SUB),
    .cin_i (cin),
    .sum_o (sum),
    .c_o   (a_c),
    .dc_o  (a_dc),
    .ov_o  (a_ov)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op_i  (op),
    .f_i   (operand_i),
    .w_i   (w_q),
    .res_o (lg_res)
  );

  assign res_d = is_arith ? sum : lg_res;

  always_comb begin
    flags_d = flags_q;
    if (is_arith) begin
      flags_d.c  = a_c;
      flags_d.dc = a_dc;
      flags_d.ov = a_ov;
    end
    if (!is_ldw) begin
      flags_d.z = ~|res_d;
      flags_d.n = res_d[DW-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q     <= '0;
      res_q   <= '0;
      flags_q <= '0;
      vld_q   <= 1'b0;
      wr_w_q  <= 1'b0;
      wr_f_q  <= 1'b0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) begin
        res_q   <= res_d;
        flags_q <= flags_d;
        wr_w_q  <= to_w;
        wr_f_q  <= !to_w;
        if (to_w) w_q <= res_d;
      end else begin
        wr_w_q <= 1'b0;
        wr_f_q <= 1'b0;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign result_o    = res_q;
  assign wr_w_o      = wr_w_q;
  assign wr_f_o      = wr_f_q;
  assign w_o         = w_q;
  assign flags_o     = flags_q;

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!res_valid_o && $stable(flags_q) && $stable(w_q)));
  // R8
  dest_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (wr_w_o ^ wr_f_o));
  // R8
  file_keeps_w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dest_f_i && !is_ldw) |=> $stable(w_q));
  // R8
  w_gets_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dest_f_i) |=> (w_o == result_o));
  // R7
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_logic) |=> $stable({flags_q.c, flags_q.dc, flags_q.ov}));
  // R9
  ldw_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_ldw) |=> $stable(flags_q));
endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       dest_f_i = 1'b0;
  logic       res_valid_o, wr_w_o, wr_f_o;
  logic [7:0] result_o, w_o;
  logic [4:0] flags_o;

  int total = 0, bad = 0;
  bit done = 0;
  int mw = 0, mc = 0, mdc = 0, mz = 0, mov = 0, mn = 0;

  always #4 clk = ~clk;

  acc_alu dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .operand_i(operand_i), .dest_f_i(dest_f_i), .res_valid_o(res_valid_o),
    .result_o(result_o), .wr_w_o(wr_w_o), .wr_f_o(wr_f_o), .w_o(w_o),
    .flags_o(flags_o)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic req(int op, int f, int d);
    int r, c, dc, ov, sa, sw, s, cin;
    string t;
    c = mc; dc = mdc; ov = mov; r = 0;
    sa = (f >= 128) ? f - 256 : f;
    sw = (mw >= 128) ? mw - 256 : mw;
    case (op)
      0, 1: begin
        cin = (op == 1) ? mc : 0;
        s  = f + mw + cin;
        r  = s & 255;
        c  = (s > 255);
        dc = (((f & 15) + (mw & 15) + cin) > 15);
        ov = ((sa + sw + cin) > 127) || ((sa + sw + cin) < -128);
      end
      2: begin
        r  = (f - mw) & 255;
        c  = (f >= mw);
        dc = ((f & 15) >= (mw & 15));
        ov = ((sa - sw) > 127) || ((sa - sw) < -128);
      end
      3: r = f;
      4: r = f & mw;
      5: r = f | mw;
      6: r = f ^ mw;
      default: r = f;
    endcase
    t = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : (op == 7) ? "R9" : "R7";
    op_i = op[2:0]; operand_i = f[7:0]; dest_f_i = d[0]; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (op == 7) mw = f;
    else if (d == 0) mw = r;
    if (op <= 2) begin mc = c; mdc = dc; mov = ov; end
    if (op != 7) begin mz = (r == 0); mn = r >> 7; end
    chk("R10 valid", res_valid_o, 1);
    chk({t, " result"}, result_o, r);
    chk("R8 w", w_o, mw);
    chk("R8 wr_w", wr_w_o, (op == 7 || d == 0));
    chk("R8 wr_f", wr_f_o, (op != 7 && d == 1));
    chk({t, " c"}, flags_o[0], mc);
    chk((op <= 1) ? "R4 dc" : {t, " dc"}, flags_o[1], mdc);
    chk((op <= 2) ? "R5 ov" : {t, " ov"}, flags_o[3], mov);
    chk((op == 7) ? "R9 z" : "R6 z", flags_o[2], mz);
    chk((op == 7) ? "R9 n" : "R6 n", flags_o[4], mn);
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R10 idle valid", res_valid_o, 0);
    chk("R10 idle w", w_o, mw);
    chk("R10 idle flags", flags_o, {mn[0], mov[0], mz[0], mdc[0], mc[0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 w", w_o, 0);
    chk("R11 flags", flags_o, 0);
    chk("R11 valid", res_valid_o, 0);
    chk("R11 wr", {wr_w_o, wr_f_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    req(7, 8'h52, 1);
    req(0, 8'h9F, 1);
    chk("R4 example result", result_o, 8'hF1);
    chk("R4 example flags", flags_o, 5'h12);
    idle();
    req(7, 8'h00, 0);   // R9 load keeps flags from example
    chk("R9 flags kept", flags_o, 5'h12);
    idle();
    for (int w = 0; w < 256; w += 5) begin
      for (int f = 0; f < 256; f += 3) begin
        for (int op = 0; op < 7; op++) begin
          req(7, w, (f >> 2) & 1);
          req(op, f, (f >> 1) & 1);
        end
      end
      idle();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule